// File: doc/BRIEF.md
# Multi-Chain Shift Register with Nibble Taps

This block is a radiation-test workload: a set of long flip-flop chains that all shift one bit on every edge of a fast clock. The tester does not watch every shift. Once every four fast cycles, the last four stages of each chain are copied into a wide output word. At that moment each chain's four stages hold exactly the four bits that will leave it next. The word is presented together with a one-cycle strobe, so a slower tester can capture it at one quarter of the shift rate. Because the four bits of each copy are the ones that leave over the following four shifts, the copied nibbles add up to the complete exit stream of every chain, with no gap and no overlap.

Data enters either from one serial input per chain or from a built-in pseudo-random source, picked by a mode input. An upset anywhere along a chain travels to the tap stages and shows up in a captured word. Comparing the words against the expected stream is left to the tester. The chain length is a parameter, so a short chain can stand in for the full one in simulation.

Top module: `mct_tap_array`

## Requirements
- R1: While `rst_n` is low, and on the first two rising clock edges after it rises, `word_o` is all zeros and `stb_o` is 0. The first shift happens on the third rising edge after release, which is the first active edge.
- R2: With `pat_sel` = 0, chain k takes `ser_in[k]` into its first stage on every active edge, and every other stage takes the value of the stage before it.
- R3: `stb_o` is high for exactly one cycle in every four. It first rises on active edge 4, and then again on edges 8, 12 and so on.
- R4: `word_o` changes only on an edge that raises `stb_o`, and it holds its value while `stb_o` is low.
- R5: Chain k drives `word_o[4k+3:4k]`. Bit 4k+3 is the chain's last stage, the oldest bit. Bit 4k is the fourth stage from the end. All four are taken from the state the chain held just before the strobing edge.
- R6: With `CHAIN_LEN` = 12, a single 1 shifted into chain 0 on active edge 1 appears as `word_o[2]` = 1 with `word_o[3]` = 0 on the third strobe, and it is gone by the fourth strobe.
- R7: With `pat_sel` = 1, every chain is fed from a 7-bit generator that is set to 7'h7F by reset. On each active edge the generator supplies its bit 6 and then shifts left, taking bit 6 XOR bit 5 into bit 0. Even-numbered chains receive that bit as it is, and odd-numbered chains receive its inverse. The generator advances on every active edge in both modes.
- R8: The chains are independent: data driven into one chain never reaches another chain's nibble.
- R9: A reset pulse in the middle of a run clears every chain, the phase of the strobe and the generator, after which the timing of R1 and R3 starts over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pat_sel | input | 1 | 0: serial inputs feed the chains; 1: built-in pattern feeds them |
| ser_in | input | NUM_CHAINS | Serial data, one bit per chain |
| word_o | output | NUM_CHAINS*4 | Captured nibbles, chain k in bits [4k+3:4k] |
| stb_o | output | 1 | One-cycle strobe marking a new word |

## Verification
A flipped stage in a chain reaches the tap stages after as many shifts as it sits from the end of the chain. It then shows at the ports in the next strobed word, so an error deep in a full-length chain takes up to about 2000 cycles to appear. A wrong phase count shows at once as a strobe out of its one-in-four cadence, or as a word that changes while the strobe is low. A fault in the pattern generator shows up in odd and even nibbles together, within one capture period of the first wrong bit reaching the taps. The bench runs a cycle-accurate model of the chains next to the design and compares both outputs on every cycle. It adds targeted checks on first-bit latency, on chain isolation and on restarting after a mid-run reset.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int TAP_W = 4;
  localparam int GEN_W = 7;
  localparam logic [GEN_W-1:0] GEN_SEED = 7'h7F;
endpackage

// File: rtl/mct_rst_sync.sv
module mct_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mct_pattern_gen.sv
module mct_pattern_gen
  import mct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic bit_o
);
  logic [GEN_W-1:0] gen_q, gen_d;
  logic             fb;

  always_comb begin
    fb    = gen_q[GEN_W-1] ^ gen_q[GEN_W-2];
    gen_d = {gen_q[GEN_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_q <= GEN_SEED;
    else        gen_q <= gen_d;
  end

  assign bit_o = gen_q[GEN_W-1];

  // R7: an XOR-feedback generator seeded non-zero never reaches the all-zero lock-up state
  assert_gen_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != '0);
endmodule

// File: rtl/mct_chain.sv
module mct_chain #(
  parameter int LEN   = 2000,
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [TAP_W-1:0] tap_o
);
  logic [LEN-1:0] stage_q, stage_d;

  always_comb stage_d = {stage_q[LEN-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign tap_o = stage_q[LEN-1 -: TAP_W];

  // R2: the oldest tap stage takes what the next tap stage held one edge earlier
  assert_tap_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o[TAP_W-1] == $past(tap_o[TAP_W-2]));
endmodule

// File: rtl/mct_capture.sv
module mct_capture #(
  parameter int WORD_W = 32,
  parameter int TAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] taps_i,
  output logic [WORD_W-1:0] word_o,
  output logic              stb_o
);
  localparam int PH_W = (TAP_W > 1) ? $clog2(TAP_W) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TAP_W - 1);

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [WORD_W-1:0] word_q;
  logic              stb_q, cap_en;

  always_comb begin
    cap_en = (ph_q == PH_LAST);
    ph_d   = cap_en ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      stb_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= taps_i;
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;

  // R3: a strobe never lasts two cycles
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R4: the word holds whenever no strobe marks it
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(word_q));
endmodule

// File: rtl/mct_tap_array.sv
module mct_tap_array
  import mct_pkg::*;
#(
  parameter int NUM_CHAINS = 8,
  parameter int CHAIN_LEN  = 2000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pat_sel,
  input  logic [NUM_CHAINS-1:0]       ser_in,
  output logic [NUM_CHAINS*TAP_W-1:0] word_o,
  output logic                        stb_o
);
  localparam int WORD_W = NUM_CHAINS * TAP_W;

  logic              srst_n;
  logic              gen_bit;
  logic [WORD_W-1:0] taps;

  mct_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mct_pattern_gen u_gen (
    .clk   (clk),
    .rst_n (srst_n),
    .bit_o (gen_bit)
  );

  for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_chain
    localparam logic INV = ((k % 2) == 1);
    logic din;
    assign din = pat_sel ? (gen_bit ^ INV) : ser_in[k];

    mct_chain #(.LEN(CHAIN_LEN), .TAP_W(TAP_W)) u_chain (
      .clk   (clk),
      .rst_n (srst_n),
      .din   (din),
      .tap_o (taps[k*TAP_W +: TAP_W])
    );
  end

  mct_capture #(.WORD_W(WORD_W), .TAP_W(TAP_W)) u_capture (
    .clk    (clk),
    .rst_n  (srst_n),
    .taps_i (taps),
    .word_o (word_o),
    .stb_o  (stb_o)
  );

  // R1: the port-level reset holds both outputs at zero
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (word_o == '0 && !stb_o));
endmodule

// File: tb/test_mct_tap_array.sv
module test_mct_tap_array;
  localparam int CLK_PERIOD = 8;
  localparam int NC  = 8;
  localparam int LEN = 12;
  localparam int WW  = NC * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pat_sel = 1'b0;
  logic [NC-1:0] ser_in = '0;
  logic [WW-1:0] word_o;
  logic          stb_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [LEN-1:0] mc [NC];
  int             mph;
  int             inert;
  logic [WW-1:0]  mword;
  logic           mstb;
  logic [6:0]     mgen;
  logic [WW-1:0]  prev_word;
  int             strobes;

  mct_tap_array #(.NUM_CHAINS(NC), .CHAIN_LEN(LEN)) i_mct_tap_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .pat_sel (pat_sel),
    .ser_in  (ser_in),
    .word_o  (word_o),
    .stb_o   (stb_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NC; k++) mc[k] = '0;
    mph = 0; mword = '0; mstb = 1'b0; mgen = 7'h7F;
  endtask

  task automatic model_step();
    logic pb, d;
    pb = mgen[6];
    mstb = (mph == 3);
    if (mstb)
      for (int k = 0; k < NC; k++) mword[k*4 +: 4] = mc[k][LEN-1 -: 4];
    for (int k = 0; k < NC; k++) begin
      d = pat_sel ? (pb ^ k[0]) : ser_in[k];
      mc[k] = {mc[k][LEN-2:0], d};
    end
    mph = (mph + 1) % 4;
    mgen = {mgen[5:0], mgen[6] ^ mgen[5]};
  endtask

  // one clock: inputs already stable, advance model at the edge, compare at the falling edge
  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_clear();
    else if (inert > 0) inert--;
    else model_step();
    @(negedge clk);
    check(stb_o === mstb, "R3 strobe cadence", {31'b0, stb_o}, {31'b0, mstb});
    check(word_o === mword, "R5 word content", word_o, mword);
    if (!stb_o) check(word_o === prev_word, "R4 hold without strobe", word_o, prev_word);
    else strobes++;
    prev_word = word_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check(word_o === '0 && stb_o === 1'b0, "R1 async reset", word_o, '0);
    prev_word = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    inert = 2;
    strobes = 0;
    tick();
    tick();
    check(word_o === '0 && stb_o === 1'b0, "R1 two inert edges", word_o, '0);
  endtask

  task automatic t_reset();
    pat_sel = 1'b0; ser_in = '1;
    do_reset();
    tick(); tick(); tick();
    check({31'b0, stb_o} === 32'd0, "R3 no strobe before edge 4", {31'b0, stb_o}, 0);
    tick();
    check({31'b0, stb_o} === 32'd1, "R3 first strobe on edge 4", {31'b0, stb_o}, 1);
  endtask

  task automatic t_first_bit();
    pat_sel = 1'b0; ser_in = '0;
    do_reset();
    ser_in = 8'h01;
    tick();
    ser_in = '0;
    while (strobes < 3) tick();
    check({30'b0, word_o[3:2]} === 32'd1, "R6 first bit at word[2] on strobe 3",
          {30'b0, word_o[3:2]}, 32'd1);
    while (strobes < 4) tick();
    check({28'b0, word_o[3:0]} === 32'd0, "R6 bit gone by strobe 4",
          {28'b0, word_o[3:0]}, 32'd0);
  endtask

  task automatic t_walk();
    pat_sel = 1'b0;
    do_reset();
    for (int i = 0; i < 5 * LEN; i++) begin
      ser_in = NC'((i * 37 + 5) ^ (i >> 2));
      tick();
    end
    check(strobes == (5 * LEN) / 4, "R2 serial stream strobes", strobes, (5 * LEN) / 4);
  endtask

  task automatic t_indep();
    logic seen_other;
    pat_sel = 1'b0; seen_other = 1'b0;
    do_reset();
    for (int i = 0; i < 4 * LEN; i++) begin
      ser_in = {2'b00, 1'(i % 3 != 0), 5'b00000};
      tick();
      if ((word_o & ~32'h00F0_0000) != 0) seen_other = 1'b1;
    end
    check(!seen_other, "R8 isolated chain", word_o & ~32'h00F0_0000, '0);
  endtask

  task automatic t_pattern();
    ser_in = '0; pat_sel = 1'b1;
    do_reset();
    repeat (6 * LEN) tick();
    check(word_o[7:4] === ~word_o[3:0], "R7 odd chain inverted", {28'b0, word_o[7:4]},
          {28'b0, ~word_o[3:0]});
  endtask

  task automatic t_midreset();
    pat_sel = 1'b1;
    do_reset();
    repeat (LEN + 7) tick();
    pat_sel = 1'b0; ser_in = '0;
    do_reset();
    repeat (3) tick();
    check({31'b0, stb_o} === 32'd0, "R9 phase restarted", {31'b0, stb_o}, 0);
    tick();
    check(word_o === '0 && stb_o === 1'b1, "R9 chains cleared", word_o, '0);
    repeat (2 * LEN) tick();
  endtask

  initial begin
    model_clear();
    inert = 2; prev_word = '0; strobes = 0;
    t_reset();
    t_first_bit();
    t_walk();
    t_indep();
    t_pattern();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule